// File: doc/BRIEF.md
# Filtered Window Comparator

This block watches a stream of conversion results and tests each one against a programmable unsigned window bounded by a low and a high threshold. Four compare conditions are available: below the window, above it, inside it, or outside it. A condition match counts only when it is met on a run of consecutive compared results. The length of that run is the programmed filter value plus one. When the run is complete, a sticky event flag is set. Software clears that flag with a read-clear pulse.

The compare can cover every channel or only one selected channel. Results from channels that are not compared do not touch the filter state. The block also drives a store-enable output for the downstream result buffer. In flag-only operation every valid result is stored. In start-condition operation nothing is stored until the filtered condition is first met. From then on every result is stored until a comparison-reset pulse arrives.

The result input is a valid/ready stream. `res_ready` is held high at all times, so the block never applies back-pressure. A result is taken in every cycle in which `res_valid` is high. Control and status pins are plain levels and pulses.

Top module: `win_cmp_unit`

## Requirements
- R1: Mode code 0 (below) matches when the result is strictly less than `thr_low`; a result equal to `thr_low` does not match.
- R2: Mode code 1 (above) matches when the result is strictly greater than `thr_high`; a result equal to `thr_high` does not match.
- R3: Mode code 2 (inside) matches when `thr_low` <= result <= `thr_high`, with both bounds included.
- R4: Mode code 3 (outside) matches exactly when mode 2 would not match.
- R5: The event flag rises in the cycle after the (`filt_cnt`+1)-th consecutive matching compared result. A compared result that does not match restarts the run from zero.
- R6: With `cmp_all` = 0, only results whose `res_chan` equals `sel_chan` are compared. Results from other channels leave the run count unchanged.
- R7: With `cmp_all` = 1, results from every channel are compared and `sel_chan` is ignored.
- R8: `evt_flag` stays set until `flag_rd_clr` is pulsed. If a new event and the clear arrive in the same cycle, the flag stays set.
- R9: With `cmp_start_type` = 0, `store_en` equals `res_valid` for every result, whatever the compare outcome.
- R10: With `cmp_start_type` = 1, `store_en` is low until the filtered condition is met. It is high in the same cycle as the result that completes the run, and stays high for every later valid result.
- R11: A `cmp_reset` pulse clears the run count and the start-condition latch, but not `evt_flag`. A result that arrives during the pulse is not counted.
- R12: After reset, `evt_flag` and `store_en` are low and `res_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result present on this cycle |
| res_ready | output | 1 | Always high; the block never stalls |
| res_data | input | 16 | Conversion result, unsigned |
| res_chan | input | 5 | Channel that produced the result |
| thr_low | input | 16 | Low window bound |
| thr_high | input | 16 | High window bound |
| cmp_mode | input | 2 | 0 below, 1 above, 2 inside, 3 outside |
| filt_cnt | input | 2 | Consecutive matches needed, minus one |
| cmp_all | input | 1 | Compare all channels |
| sel_chan | input | 5 | Channel compared when `cmp_all` is 0 |
| cmp_start_type | input | 1 | 0 flag only, 1 start condition |
| cmp_reset | input | 1 | Pulse clearing the run count and the start latch |
| flag_rd_clr | input | 1 | Pulse clearing the event flag |
| evt_flag | output | 1 | Sticky compare event flag |
| store_en | output | 1 | Current valid result is to be stored |

## Verification
Each mode is driven with values on both sides of each bound and exactly on the bound. This separates strict comparisons from inclusive ones, and it separates inside from outside. Filter runs are built from matching results, broken by a single miss, and interleaved with results from other channels. These runs show whether a miss restarts the count and whether an ignored channel leaves it alone. Start-condition sequences mix misses before and after the trigger, then add a reset pulse. They show when storage opens, that it stays open, and that it closes again.

// File: rtl/win_cmp_pkg.sv
package win_cmp_pkg;
  typedef enum logic [1:0] {
    CMP_BELOW   = 2'd0,
    CMP_ABOVE   = 2'd1,
    CMP_INSIDE  = 2'd2,
    CMP_OUTSIDE = 2'd3
  } cmp_mode_e;
endpackage

// File: rtl/win_cmp_match.sv
module win_cmp_match
  import win_cmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 5
) (
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic [DATA_W-1:0] thr_low,
  input  logic [DATA_W-1:0] thr_high,
  input  logic [1:0]        cmp_mode,
  input  logic              cmp_all,
  input  logic [CHAN_W-1:0] sel_chan,
  output logic              cmp_vld,
  output logic              cmp_hit
);
  logic below_w, above_w, in_w;

  assign below_w = res_data < thr_low;
  assign above_w = res_data > thr_high;
  assign in_w    = !below_w && !above_w;
  assign cmp_vld = res_valid && (cmp_all || (res_chan == sel_chan));

  always_comb begin
    unique case (cmp_mode_e'(cmp_mode))
      CMP_BELOW:   cmp_hit = below_w;
      CMP_ABOVE:   cmp_hit = above_w;
      CMP_INSIDE:  cmp_hit = in_w;
      CMP_OUTSIDE: cmp_hit = !in_w;
      default:     cmp_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/win_cmp_filter.sv
module win_cmp_filter #(
  parameter int FILT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_vld,
  input  logic              cmp_hit,
  input  logic [FILT_W-1:0] filt_cnt,
  input  logic              cmp_reset,
  input  logic              flag_rd_clr,
  output logic              fire,
  output logic              evt_flag
);
  logic [FILT_W-1:0] run_q;
  logic              take;

  assign take = cmp_vld && !cmp_reset;
  assign fire = take && cmp_hit && (run_q >= filt_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (cmp_reset)        run_q <= '0;
    else if (take && !cmp_hit) run_q <= '0;
    else if (take && !fire)    run_q <= run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           evt_flag <= 1'b0;
    else if (fire)        evt_flag <= 1'b1;
    else if (flag_rd_clr) evt_flag <= 1'b0;
  end

  assert_miss_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld && !cmp_hit) |=> (run_q == '0));
  assert_skip_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_vld && !cmp_reset) |=> $stable(run_q));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !flag_rd_clr) |=> evt_flag);
  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(cmp_vld && cmp_hit));
endmodule

// File: rtl/win_cmp_start.sv
module win_cmp_start (
  input  logic clk,
  input  logic rst_n,
  input  logic res_valid,
  input  logic start_type,
  input  logic fire,
  input  logic cmp_reset,
  output logic store_en
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  open_q <= 1'b0;
    else if (cmp_reset)          open_q <= 1'b0;
    else if (start_type && fire) open_q <= 1'b1;
  end

  assign store_en = res_valid && (!start_type || open_q || fire);

  assert_reset_closes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_reset |=> !open_q);
  assert_open_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !cmp_reset) |=> open_q);
endmodule

// File: rtl/win_cmp_unit.sv
module win_cmp_unit #(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 5,
  parameter int FILT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic [DATA_W-1:0] thr_low,
  input  logic [DATA_W-1:0] thr_high,
  input  logic [1:0]        cmp_mode,
  input  logic [FILT_W-1:0] filt_cnt,
  input  logic              cmp_all,
  input  logic [CHAN_W-1:0] sel_chan,
  input  logic              cmp_start_type,
  input  logic              cmp_reset,
  input  logic              flag_rd_clr,
  output logic              evt_flag,
  output logic              store_en
);
  logic cmp_vld, cmp_hit, fire;

  assign res_ready = 1'b1;

  win_cmp_match #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_match (
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .thr_low(thr_low), .thr_high(thr_high), .cmp_mode(cmp_mode),
    .cmp_all(cmp_all), .sel_chan(sel_chan),
    .cmp_vld(cmp_vld), .cmp_hit(cmp_hit)
  );

  win_cmp_filter #(.FILT_W(FILT_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .cmp_vld(cmp_vld), .cmp_hit(cmp_hit),
    .filt_cnt(filt_cnt), .cmp_reset(cmp_reset), .flag_rd_clr(flag_rd_clr),
    .fire(fire), .evt_flag(evt_flag)
  );

  win_cmp_start u_start (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid),
    .start_type(cmp_start_type), .fire(fire), .cmp_reset(cmp_reset),
    .store_en(store_en)
  );

  assert_flag_only_stores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cmp_start_type) |-> store_en);
  assert_ignored_chan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cmp_all && (res_chan != sel_chan) && !evt_flag && !flag_rd_clr)
      |=> !evt_flag);
endmodule

// File: tb/tb_win_cmp_unit.sv
module tb_win_cmp_unit;
  logic        clk = 0, rst_n = 0;
  logic        res_valid = 0, res_ready;
  logic [15:0] res_data = 0, thr_low = 100, thr_high = 200;
  logic [4:0]  res_chan = 0, sel_chan = 0;
  logic [1:0]  cmp_mode = 0, filt_cnt = 0;
  logic        cmp_all = 1, cmp_start_type = 0, cmp_reset = 0, flag_rd_clr = 0;
  logic        evt_flag, store_en;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  win_cmp_unit dut (.*);

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // drive one result; store_en sampled mid-cycle, flag after the edge
  task automatic push(input logic [15:0] d, input logic [4:0] ch,
                      input logic exp_flag, input string req);
    @(negedge clk);
    res_valid = 1; res_data = d; res_chan = ch;
    @(negedge clk);
    res_valid = 0;
    chk(evt_flag, exp_flag, req);
  endtask

  task automatic push_st(input logic [15:0] d, input logic exp_st, input string req);
    @(negedge clk);
    res_valid = 1; res_data = d; res_chan = 0;
    #1 chk(store_en, exp_st, req);
    @(negedge clk);
    res_valid = 0;
  endtask

  task automatic clr();
    @(negedge clk); flag_rd_clr = 1;
    @(negedge clk); flag_rd_clr = 0;
  endtask

  task automatic creset();
    @(negedge clk); cmp_reset = 1;
    @(negedge clk); cmp_reset = 0;
  endtask

  task automatic t_reset();
    chk(evt_flag, 0, "R12 flag");
    chk(store_en, 0, "R12 store");
    chk(res_ready, 1, "R12 ready");
  endtask

  task automatic t_below();
    cmp_mode = 0; filt_cnt = 0; clr();
    push(100, 0, 0, "R1 equal low");
    push(99, 0, 1, "R1 below");
    clr(); chk(evt_flag, 0, "R8 clear");
  endtask

  task automatic t_above();
    cmp_mode = 1; clr();
    push(200, 0, 0, "R2 equal high");
    push(150, 0, 0, "R2 inside");
    push(201, 0, 1, "R2 above");
    clr();
  endtask

  task automatic t_inside();
    cmp_mode = 2; clr();
    push(99, 0, 0, "R3 below");
    push(100, 0, 1, "R3 low bound"); clr();
    push(200, 0, 1, "R3 high bound"); clr();
    push(201, 0, 0, "R3 above");
  endtask

  task automatic t_outside();
    cmp_mode = 3; clr();
    push(100, 0, 0, "R4 low bound");
    push(200, 0, 0, "R4 high bound");
    push(99, 0, 1, "R4 below"); clr();
    push(201, 0, 1, "R4 above"); clr();
  endtask

  task automatic t_filter();
    cmp_mode = 0; filt_cnt = 2; clr();
    push(10, 0, 0, "R5 m1");
    push(10, 0, 0, "R5 m2");
    push(150, 0, 0, "R5 miss");
    push(10, 0, 0, "R5 m1 again");
    push(10, 0, 0, "R5 m2 again");
    push(10, 0, 1, "R5 third match");
    push(150, 0, 1, "R8 sticky");
    clr();
  endtask

  task automatic t_chan();
    cmp_mode = 0; filt_cnt = 1; cmp_all = 0; sel_chan = 3; clr();
    push(10, 5, 0, "R6 other chan match");
    push(10, 5, 0, "R6 other chan match 2");
    push(10, 3, 0, "R6 sel m1");
    push(150, 7, 0, "R6 other chan miss");
    push(10, 3, 1, "R6 run kept");
    clr();
    cmp_all = 1; filt_cnt = 0;
    push(10, 9, 1, "R7 any chan"); clr();
    sel_chan = 0;
  endtask

  task automatic t_setwins();
    cmp_mode = 0; filt_cnt = 0; clr();
    @(negedge clk);
    res_valid = 1; res_data = 5; flag_rd_clr = 1;
    @(negedge clk);
    res_valid = 0; flag_rd_clr = 0;
    chk(evt_flag, 1, "R8 set wins");
    clr();
  endtask

  task automatic t_type0();
    cmp_start_type = 0; cmp_mode = 0; filt_cnt = 0;
    push_st(150, 1, "R9 miss stored");
    push_st(5, 1, "R9 hit stored");
    clr();
  endtask

  task automatic t_type1();
    cmp_start_type = 1; cmp_mode = 0; filt_cnt = 1; creset(); clr();
    push_st(150, 0, "R10 miss before");
    push_st(5, 0, "R10 first match");
    push_st(5, 1, "R10 trigger");
    push_st(150, 1, "R10 after miss");
    chk(evt_flag, 1, "R10 flag");
    creset();
    chk(evt_flag, 1, "R11 flag kept");
    push_st(150, 0, "R11 closed");
    push_st(5, 0, "R11 m1");
    creset();
    push_st(5, 0, "R11 count cleared");
    push_st(5, 1, "R11 reopen");
    cmp_start_type = 0; creset(); clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_below();
    t_above();
    t_inside();
    t_outside();
    t_filter();
    t_chan();
    t_setwins();
    t_type0();
    t_type1();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule